// File: doc/BRIEF.md
# Four-Tap Gaussian Sample Interpolator

This block turns a stream of decoded audio samples into a pitch-shifted output by weighting the last four samples with a bell-shaped kernel. A producer raises a one-cycle step strobe with each new 16-bit signed sample and the current 12-bit fractional phase of its pitch counter. On that strobe the block pushes the sample into a four-entry history, in which the oldest sample drops out. It then reads four signed coefficients from a 512-entry constant kernel at positions picked by the phase. It multiplies each coefficient by its history sample, scales each product down and sums the four results.

The result appears on a registered output one cycle after the strobe, together with a one-cycle valid pulse. Between strobes the history and the output hold still. Sample decoding, pitch counting and voice mixing are done elsewhere. The kernel is computed at elaboration time from a closed formula, so no table literal is kept in the source.

Top module: `gauss_interp`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `out_o` is 0, `out_valid_o` is 0 and all four history entries are 0.
- R2: On a strobe, history entry 0 (newest) takes `smp_i`, and entries 1, 2 and 3 take the old values of entries 0, 1 and 2. The old entry 3 is discarded.
- R3: The kernel index is `phase_i[11:4]`. Bits 3:0 of the phase have no effect on the result.
- R4: With kernel index p, the newest sample is weighted by entry p, the second-newest by entry 256+p, the second-oldest by entry 511-p and the oldest by entry 255-p.
- R5: Kernel entry k equals floor(k^3/3072)-1 for k<256. For k>=256, with e=512-k, it equals floor((67108864-1536*e^2+3*e^3)/3072)-1. So entries 0..14 are -1, entry 15 is 0, entry 255 is 5396, entry 256 is 5460 and entry 511 is 21843.
- R6: Each 32-bit signed product of coefficient and sample is shifted right arithmetically by 15 (rounding toward minus infinity) before the four are added.
- R7: The sum is clamped to the signed 16-bit range. With every history entry at -32768 or at 32767, the output equals the exact unclamped sum.
- R8: `out_valid_o` is 1 exactly in the cycle after a strobe. `out_o` then holds the result computed from the updated history and the phase presented with that strobe.
- R9: In a cycle without a strobe, changes on `smp_i` and `phase_i` have no effect. The history and `out_o` keep their values and `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One-cycle strobe: accept a new sample and produce a result |
| smp_i | input | 16 | Signed decoded sample, sampled with `step_i` |
| phase_i | input | 12 | Fractional pitch phase, sampled with `step_i` |
| out_o | output | 16 | Signed interpolated sample, registered |
| out_valid_o | output | 1 | High for one cycle when `out_o` is updated |

## Verification
The hardest case to reach from the ports is seeing what one tap contributes, because every result mixes all four history entries. The bench starts from the cleared history and pushes a single -32768 impulse, then zeros. The impulse then walks through positions 0 to 3, and the output is the negated kernel entry that the tap under test selects. Fixed kernel values are checked for phase indices 0, 14, 15 and 255. After that, pseudo-random samples and phases are compared with an independent model, and full-scale histories show that the clamp never cuts a legal sum.

// File: rtl/gauss_interp_pkg.sv
package gauss_interp_pkg;

   // Number of history taps; the kernel address mapping is defined for four.
   localparam int TAPS        = 4;
   // Kernel positions per half of the symmetric bell.
   localparam int KERNEL_HALF = 256;

   // Cubic B-spline bell scaled to 2^15, biased down by one.
   // Lower half: outer spline segment; upper half: inner segment.
   function automatic int kernel_at(input int k);
      int a;
      int e;
      a = k;
      e = 2 * KERNEL_HALF - k;
      if (k < KERNEL_HALF)
         return (a * a * a) / 3072 - 1;
      return (67108864 - 1536 * e * e + 3 * e * e * e) / 3072 - 1;
   endfunction

endpackage

// File: rtl/gi_history.sv
module gi_history #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_i,
   input  logic signed [W-1:0] din_i,
   output logic signed [W-1:0] q_o   [DEPTH],
   output logic signed [W-1:0] nxt_o [DEPTH]
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("gi_history: DEPTH must be at least 2");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_tap
      if (g == 0) begin : g_head
         assign nxt_o[g] = din_i;
      end else begin : g_body
         assign nxt_o[g] = q_o[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q_o[g] <= '0;
         else if (push_i)
            q_o[g] <= nxt_o[g];
      end
   end

endmodule

// File: rtl/gi_coef_rom.sv
module gi_coef_rom #(
   parameter int IDX_W  = 8,
   parameter int COEF_W = 16
) (
   input  logic        [IDX_W-1:0]  idx_i,
   output logic signed [COEF_W-1:0] coef_o [gauss_interp_pkg::TAPS]
);

   localparam int HALF    = 1 << IDX_W;
   localparam int ENTRIES = 2 * HALF;
   localparam int AW      = IDX_W + 1;

   if (HALF != gauss_interp_pkg::KERNEL_HALF) begin : g_bad_idx
      $error("gi_coef_rom: kernel formula is defined for IDX_W == 8");
   end
   if (COEF_W < 16) begin : g_bad_coef
      $error("gi_coef_rom: COEF_W must hold the kernel peak");
   end
   if (gauss_interp_pkg::TAPS != 4) begin : g_bad_taps
      $error("gi_coef_rom: address mapping needs four taps");
   end

   function automatic logic [ENTRIES*COEF_W-1:0] build_rom();
      logic [ENTRIES*COEF_W-1:0] r;
      r = '0;
      for (int k = 0; k < ENTRIES; k++)
         r[k*COEF_W +: COEF_W] = COEF_W'(gauss_interp_pkg::kernel_at(k));
      return r;
   endfunction

   localparam logic [ENTRIES*COEF_W-1:0] ROM = build_rom();

   // Tap 0 is the newest sample, tap 3 the oldest.
   for (genvar t = 0; t < gauss_interp_pkg::TAPS; t++) begin : g_tap
      logic [AW-1:0] addr;
      if (t == 0) begin : g_newest
         assign addr = {1'b0, idx_i};
      end else if (t == 1) begin : g_newer
         assign addr = {1'b1, idx_i};
      end else if (t == 2) begin : g_older
         assign addr = {1'b1, ~idx_i};
      end else begin : g_oldest
         assign addr = {1'b0, ~idx_i};
      end
      assign coef_o[t] = ROM[addr*COEF_W +: COEF_W];
   end

endmodule

// File: rtl/gi_mac.sv
module gi_mac #(
   parameter int SMP_W    = 16,
   parameter int COEF_W   = 16,
   parameter int SHIFT    = 15,
   parameter int OUT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [SMP_W-1:0]  smp_i  [gauss_interp_pkg::TAPS],
   input  logic signed [COEF_W-1:0] coef_i [gauss_interp_pkg::TAPS],
   output logic signed [OUT_W-1:0]  sum_o
);

   localparam int TAPS = gauss_interp_pkg::TAPS;
   localparam int PW   = SMP_W + COEF_W;
   localparam int SW   = PW + $clog2(TAPS);

   if (SHIFT >= PW) begin : g_bad_shift
      $error("gi_mac: SHIFT must be below the product width");
   end
   if (OUT_W > SW) begin : g_bad_out
      $error("gi_mac: OUT_W wider than the accumulator");
   end

   logic signed [SW-1:0] scaled [TAPS];
   logic signed [SW-1:0] acc;

   for (genvar t = 0; t < TAPS; t++) begin : g_prod
      logic signed [PW-1:0] prod;
      assign prod      = smp_i[t] * coef_i[t];
      assign scaled[t] = SW'(prod >>> SHIFT);
   end

   always_comb begin
      acc = '0;
      for (int t = 0; t < TAPS; t++)
         acc = acc + scaled[t];
   end

   if (SATURATE) begin : g_sat
      localparam logic signed [SW-1:0] OMAX = SW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
      localparam logic signed [SW-1:0] OMIN = -OMAX - SW'(1);
      always_comb begin
         if (acc > OMAX)
            sum_o = OMAX[OUT_W-1:0];
         else if (acc < OMIN)
            sum_o = OMIN[OUT_W-1:0];
         else
            sum_o = acc[OUT_W-1:0];
      end
   end else begin : g_wrap
      assign sum_o = OUT_W'(acc);
   end

endmodule

// File: rtl/gauss_interp.sv
module gauss_interp #(
   parameter int SMP_W    = 16,
   parameter int COEF_W   = 16,
   parameter int PHASE_W  = 12,
   parameter int IDX_W    = 8,
   parameter int FRAC_LSB = 4,
   parameter int SHIFT    = 15,
   parameter int OUT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step_i,
   input  logic signed [SMP_W-1:0]  smp_i,
   input  logic        [PHASE_W-1:0] phase_i,
   output logic signed [OUT_W-1:0]  out_o,
   output logic                     out_valid_o
);

   localparam int TAPS = gauss_interp_pkg::TAPS;

   if (FRAC_LSB + IDX_W > PHASE_W) begin : g_bad_phase
      $error("gauss_interp: index slice exceeds the phase width");
   end

   logic        [IDX_W-1:0]  idx;
   logic signed [COEF_W-1:0] coef     [TAPS];
   logic signed [SMP_W-1:0]  hist_q   [TAPS];
   logic signed [SMP_W-1:0]  hist_nxt [TAPS];
   logic signed [OUT_W-1:0]  sum;

   assign idx = IDX_W'(phase_i >> FRAC_LSB);

   gi_coef_rom #(
      .IDX_W  (IDX_W),
      .COEF_W (COEF_W)
   ) u_rom (
      .idx_i  (idx),
      .coef_o (coef)
   );

   gi_history #(
      .W     (SMP_W),
      .DEPTH (TAPS)
   ) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (step_i),
      .din_i  (smp_i),
      .q_o    (hist_q),
      .nxt_o  (hist_nxt)
   );

   // The MAC sees the history as it will be after this strobe.
   gi_mac #(
      .SMP_W    (SMP_W),
      .COEF_W   (COEF_W),
      .SHIFT    (SHIFT),
      .OUT_W    (OUT_W),
      .SATURATE (SATURATE)
   ) u_mac (
      .smp_i  (hist_nxt),
      .coef_i (coef),
      .sum_o  (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_o       <= '0;
         out_valid_o <= 1'b0;
      end else begin
         out_valid_o <= step_i;
         if (step_i)
            out_o <= sum;
      end
   end

endmodule

// File: rtl/gauss_interp_chk.sv
module gauss_interp_chk #(
   parameter int SMP_W = 16,
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    step_i,
   input logic signed [SMP_W-1:0] smp_i,
   input logic signed [OUT_W-1:0] out_o,
   input logic                    out_valid_o,
   input logic signed [SMP_W-1:0] h0,
   input logic signed [SMP_W-1:0] h1,
   input logic signed [SMP_W-1:0] h3
);

   // R1: reset holds the outputs idle
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid_o && out_o == '0));

   // R2: newest entry takes the strobed sample
   p_newest_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (h0 == $past(smp_i)));

   // R2: previous newest moves one place back
   p_shift_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (h1 == $past(h0)));

   // R8: valid follows a strobe by one cycle
   p_valid_after_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> out_valid_o);

   // R9: no strobe, no valid and a stable output
   p_quiet_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> (!out_valid_o && $stable(out_o)));

   // R9: no strobe, history frozen
   p_quiet_history_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> ($stable(h0) && $stable(h1) && $stable(h3)));

endmodule

bind gauss_interp gauss_interp_chk #(
   .SMP_W (SMP_W),
   .OUT_W (OUT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .step_i      (step_i),
   .smp_i       (smp_i),
   .out_o       (out_o),
   .out_valid_o (out_valid_o),
   .h0          (hist_q[0]),
   .h1          (hist_q[1]),
   .h3          (hist_q[3])
);

// File: tb/gauss_interp_tb.sv
module gauss_interp_tb;

   localparam int CLK_P = 10;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               step_i;
   logic signed [15:0] smp_i;
   logic        [11:0] phase_i;
   logic signed [15:0] out_o;
   logic               out_valid_o;

   int     n_run  = 0;
   int     n_fail = 0;
   longint h [4];
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #(CLK_P/2) clk = ~clk;

   gauss_interp u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step_i),
      .smp_i       (smp_i),
      .phase_i     (phase_i),
      .out_o       (out_o),
      .out_valid_o (out_valid_o)
   );

   // Independent kernel model (R5)
   function automatic longint kern(input int k);
      longint x;
      if (k <= 255) begin
         x = longint'(k);
         return (x * x * x) / 3072 - 1;
      end
      x = longint'(512 - k);
      return (longint'(3) * x * x * x - longint'(1536) * x * x + longint'(67108864)) / 3072 - 1;
   endfunction

   function automatic longint model_out(input int ph);
      int     p;
      longint s;
      p = (ph >> 4) & 255;
      s = ((kern(p) * h[0]) >>> 15) + ((kern(256 + p) * h[1]) >>> 15)
        + ((kern(511 - p) * h[2]) >>> 15) + ((kern(255 - p) * h[3]) >>> 15);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   // One strobe; checks valid and the model result, returns the output
   task automatic push(input longint s, input int ph, input string req, output longint got);
      @(negedge clk);
      step_i  = 1'b1;
      smp_i   = 16'(s);
      phase_i = 12'(ph);
      h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = longint'(16'sh0 + $signed(16'(s)));
      @(negedge clk);
      step_i = 1'b0;
      check("R8 valid", longint'(out_valid_o), 1);
      got = longint'(out_o);
      check(req, got, model_out(ph));
   endtask

   task automatic t_reset;
      rst_n = 1'b0; step_i = 1'b0; smp_i = '0; phase_i = '0;
      for (int i = 0; i < 4; i++) h[i] = 0;
      repeat (3) @(negedge clk);
      check("R1 out in reset", longint'(out_o), 0);
      check("R1 valid in reset", longint'(out_valid_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 out after release", longint'(out_o), 0);
      check("R1 valid after release", longint'(out_valid_o), 0);
   endtask

   // Impulse walks through the taps: each output is minus one kernel entry
   task automatic t_impulse(input int p, input longint e0, input longint e1,
                            input longint e2, input longint e3);
      longint g;
      push(-32768, p << 4, "R4 tap0", g); check("R4 R5 newest entry", g, e0);
      push(0, p << 4, "R4 tap1", g);      check("R4 R5 second-newest entry", g, e1);
      push(0, (p << 4) | 9, "R3 tap2", g); check("R3 R4 second-oldest entry", g, e2);
      push(0, p << 4, "R4 tap3", g);      check("R2 R4 oldest entry", g, e3);
      push(0, p << 4, "R2 drop", g);      check("R2 impulse discarded", g, 0);
   endtask

   task automatic t_kernel_edges;
      longint g;
      push(-32768, 14 << 4, "R5 k14", g); check("R5 entry 14", g, 1);
      push(0, 0, "R5 flush", g);
      push(0, 0, "R5 flush", g);
      push(0, 0, "R5 flush", g);
      push(0, 0, "R5 flush", g);
      push(-32768, (15 << 4) | 15, "R5 k15", g); check("R3 R5 entry 15", g, 0);
      for (int i = 0; i < 4; i++) push(0, 0, "R5 flush", g);
   endtask

   task automatic t_low_bits;
      longint a, b;
      push(12000, 16'h0A3 << 4, "R3 load", a);
      push(-7000, 16'h0A3 << 4, "R3 load", a);
      push(3000, 16'h0A3 << 4, "R3 load", a);
      push(900, (8'hA3 << 4) | 4'h0, "R3 base", a);
      push(12000, 16'h0A3 << 4, "R3 load", b);
      push(-7000, 16'h0A3 << 4, "R3 load", b);
      push(3000, 16'h0A3 << 4, "R3 load", b);
      push(900, (8'hA3 << 4) | 4'hF, "R3 low bits", b);
      check("R3 low phase bits ignored", b, a);
   endtask

   task automatic t_random(input int n);
      longint g;
      for (int i = 0; i < n; i++) begin
         lfsr = next_rand(lfsr);
         push(longint'($signed(lfsr[15:0])), int'(lfsr[27:16]), "R6 random", g);
      end
   endtask

   task automatic t_full_scale;
      longint g;
      longint ex;
      for (int i = 0; i < 4; i++) push(-32768, 0, "R7 fill", g);
      ex = -(kern(0) + kern(256) + kern(511) + kern(255));
      check("R7 min full scale idx0", g, ex);
      push(-32768, 128 << 4, "R7 min idx128", g);
      for (int i = 0; i < 4; i++) push(32767, 255 << 4, "R7 max", g);
      ex = ((kern(255) * 32767) >>> 15) + ((kern(511) * 32767) >>> 15)
         + ((kern(256) * 32767) >>> 15) + ((kern(0) * 32767) >>> 15);
      check("R6 R7 max full scale idx255", g, ex);
   endtask

   task automatic t_hold;
      longint g;
      longint held;
      push(4321, 77 << 4, "R9 setup", g);
      held = longint'(out_o);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         lfsr = next_rand(lfsr);
         smp_i   = lfsr[15:0];
         phase_i = lfsr[27:16];
         @(negedge clk);
         check("R9 valid stays low", longint'(out_valid_o), 0);
         check("R9 output held", longint'(out_o), held);
      end
      push(0, 0, "R9 history untouched", g);
   endtask

   initial begin
      t_reset;
      // idx 0: entries 0, 256, 511, 255 for taps 0..3
      t_impulse(0, 1, -5460, -21843, -5396);
      // idx 255: entries 255, 511, 256, 0
      t_impulse(255, -5396, -21843, -5460, 1);
      t_kernel_edges;
      t_low_bits;
      t_hold;
      t_full_scale;
      t_random(300);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule